// File: doc/BRIEF.md
# Ping-Pong Row Readout Sequencer

This block is the digital acquisition controller for a multi-channel integrating front end that reads one sensor row per time slot. A periodic slot-control input, kept in step with the beam trigger, sets the pace. While slot control is high, the front end samples the current row into one of two per-channel sample banks. While it is low, the sequencer reads out the row that is already stored and then resets the amplifiers. The two banks swap roles on every slot. This lets the row sampled in one slot be read out during the next slot, with no dead time between rows.

The channels are arranged as several groups of equal size, and every group has its own channel selector. The sequencer drives one shared channel index that steps through all groups in parallel. Each channel also has a coarse overflow flag, which records a comparator firing during sampling. That flag is banked in the same way as the analog samples, so the bit that appears on a group's digital output always belongs to the residue being selected. After the scan, a front-end reset pulse of programmable width is issued and the flags just read are cleared. If slot control rises again before the scan and reset have finished, the sequence is cut short and a sticky overrun flag is set.

Top module: `slot_readout_seq`

## Requirements
- R1: While rstN is low and after it is released, sampleBank=0, readBank=1, and sampleEn, scanValid, feReset, overrun and all ovfBit outputs are 0.
- R2: sampleBank inverts on the second rising clock edge after slotCtrl goes from 0 to 1, and at no other time. readBank is always the inverse of sampleBank.
- R3: sampleEn goes high on the second clock edge after slotCtrl rises and goes low on the first clock edge after slotCtrl falls. It is never high together with scanValid or feReset.
- R4: On the second clock edge after slotCtrl falls, scanValid goes high for 16 consecutive cycles, with chanIdx equal to 0, 1, …, 15 in those cycles.
- R5: A cmpFire[c] bit that is high in a cycle with sampleEn high sets the flag of channel c in the bank being sampled. During the scan in the following slot, ovfBit[c/16] is 1 in the cycle where chanIdx equals c%16. In every other scan cycle, and whenever scanValid is low, each ovfBit is 0.
- R6: A cmpFire bit that is high while sampleEn is low is ignored: the channel's flag reads 0 in the next scan of that bank.
- R7: In the cycle after the chanIdx=15 scan cycle, feReset goes high for max(rstWidth,1) cycles and then returns low.
- R8: At the end of the reset pulse, the flags of the bank just read are cleared. A flag therefore shows up in one scan only, unless the channel fires again.
- R9: If slotCtrl rises while scanValid or feReset is high, then on the second edge after that rise overrun goes to 1, scanValid and feReset go low, and the flags of the bank being read are cleared. overrun then stays 1 until reset.
- R10: overrun stays 0 when every slot keeps slotCtrl low long enough for the scan and the reset pulse to finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotCtrl | input | 1 | Slot control: high = sampling phase, low = readout phase |
| cmpFire | input | NUM_GROUPS*CH_PER_GROUP | Per-channel overflow comparator outputs |
| rstWidth | input | RW_W | Front-end reset pulse width in cycles (0 acts as 1) |
| sampleBank | output | 1 | Bank currently steered to sampling |
| readBank | output | 1 | Bank currently steered to the channel selectors |
| sampleEn | output | 1 | Sampling strobe for the active phase |
| scanValid | output | 1 | chanIdx and ovfBit carry a readout channel |
| chanIdx | output | $clog2(CH_PER_GROUP) | Channel index within every group |
| ovfBit | output | NUM_GROUPS | Overflow flag of the selected channel, one per group |
| feReset | output | 1 | Reset pulse to both amplifier stages |
| overrun | output | 1 | Sticky: a slot began before readout completed |

## Verification
Every result has a fixed latency, because slot control passes through two register stages before anything acts on it. The bank flip, the rise of sampleEn and an overrun abort appear on the second edge after slotCtrl rises. sampleEn falls on the first edge after slotCtrl falls, and the first scan cycle follows on the second edge. The reset pulse starts on the edge right after channel 15. The bench changes inputs and samples outputs only on falling clock edges, and it counts negative edges from each slotCtrl change to the exact cycle where each result is due. An overflow flag is checked one slot later than the firing that set it, because that is when its bank comes up for readout.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RST  = 2'd2
  } scanState_e;

  // Strobes from the control path to the flag datapath
  typedef struct packed {
    logic setEn;    // capture comparator firings
    logic setSel;   // bank receiving captures
    logic clrEn;    // clear one bank
    logic clrSel;   // bank to clear
    logic readEn;   // present selected flags
    logic readSel;  // bank presented to the selectors
  } bankCtl_t;

endpackage

// File: rtl/slot_seq_ctrl.sv
module slot_seq_ctrl
  import slot_seq_pkg::*;
#(
  parameter int CH_PER_GROUP = 16,
  parameter int RW_W         = 4,
  localparam int IDX_W       = $clog2(CH_PER_GROUP)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotCtrl,
  input  logic [RW_W-1:0]  rstWidth,
  output bankCtl_t         ctl,
  output logic [IDX_W-1:0] chanIdx,
  output logic             bankSel,
  output logic             sampleEn,
  output logic             scanValid,
  output logic             feReset,
  output logic             overrun
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CH_PER_GROUP - 1);

  logic            slotQ, slotQ2;
  logic            riseNow, fallNow, pulseDone;
  scanState_e      state;
  logic [IDX_W-1:0] idx;
  logic [RW_W-1:0]  cnt;

  assign riseNow   = slotQ & ~slotQ2;
  assign fallNow   = ~slotQ & slotQ2;
  assign pulseDone = (state == ST_RST) && (cnt >= rstWidth);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ   <= 1'b0;
      slotQ2  <= 1'b0;
      bankSel <= 1'b0;
      state   <= ST_IDLE;
      idx     <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      slotQ  <= slotCtrl;
      slotQ2 <= slotQ;
      if (riseNow) bankSel <= ~bankSel;
      unique case (state)
        ST_IDLE: begin
          if (fallNow) begin
            state <= ST_SCAN;
            idx   <= '0;
          end
        end
        ST_SCAN: begin
          if (riseNow) begin
            state   <= ST_IDLE;
            overrun <= 1'b1;
          end else if (idx == LAST_IDX) begin
            state <= ST_RST;
            cnt   <= RW_W'(1);
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_RST: begin
          if (riseNow) begin
            state   <= ST_IDLE;
            overrun <= 1'b1;
          end else if (pulseDone) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.setEn   = slotQ & slotQ2;
    ctl.setSel  = bankSel;
    ctl.clrEn   = (state != ST_IDLE) && (riseNow || pulseDone);
    ctl.clrSel  = ~bankSel;
    ctl.readEn  = (state == ST_SCAN);
    ctl.readSel = ~bankSel;
  end

  assign chanIdx   = idx;
  assign sampleEn  = slotQ & slotQ2;
  assign scanValid = (state == ST_SCAN);
  assign feReset   = (state == ST_RST);

endmodule

// File: rtl/slot_seq_flags.sv
module slot_seq_flags
  import slot_seq_pkg::*;
#(
  parameter int NUM_GROUPS   = 6,
  parameter int CH_PER_GROUP = 16,
  localparam int NUM_CH      = NUM_GROUPS * CH_PER_GROUP,
  localparam int IDX_W       = $clog2(CH_PER_GROUP),
  localparam int CH_W        = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankCtl_t              ctl,
  input  logic [NUM_CH-1:0]     cmpFire,
  input  logic [IDX_W-1:0]      chanIdx,
  output logic [NUM_GROUPS-1:0] ovfBit
);

  logic [NUM_CH-1:0] flagBank [2];
  logic [NUM_CH-1:0] readRow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagBank[0] <= '0;
      flagBank[1] <= '0;
    end else begin
      if (ctl.clrEn) flagBank[ctl.clrSel] <= '0;
      if (ctl.setEn) flagBank[ctl.setSel] <= flagBank[ctl.setSel] | cmpFire;
    end
  end

  assign readRow = flagBank[ctl.readSel];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    logic [CH_W-1:0] pos;
    assign pos       = CH_W'(g * CH_PER_GROUP) + CH_W'(chanIdx);
    assign ovfBit[g] = ctl.readEn & readRow[pos];
  end

endmodule

// File: rtl/slot_readout_seq.sv
module slot_readout_seq
  import slot_seq_pkg::*;
#(
  parameter int NUM_GROUPS   = 6,
  parameter int CH_PER_GROUP = 16,
  parameter int RW_W         = 4,
  localparam int NUM_CH      = NUM_GROUPS * CH_PER_GROUP,
  localparam int IDX_W       = $clog2(CH_PER_GROUP)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  slotCtrl,
  input  logic [NUM_CH-1:0]     cmpFire,
  input  logic [RW_W-1:0]       rstWidth,
  output logic                  sampleBank,
  output logic                  readBank,
  output logic                  sampleEn,
  output logic                  scanValid,
  output logic [IDX_W-1:0]      chanIdx,
  output logic [NUM_GROUPS-1:0] ovfBit,
  output logic                  feReset,
  output logic                  overrun
);

  bankCtl_t ctl;
  logic     bankSel;

  slot_seq_ctrl #(
    .CH_PER_GROUP(CH_PER_GROUP),
    .RW_W        (RW_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotCtrl (slotCtrl),
    .rstWidth (rstWidth),
    .ctl      (ctl),
    .chanIdx  (chanIdx),
    .bankSel  (bankSel),
    .sampleEn (sampleEn),
    .scanValid(scanValid),
    .feReset  (feReset),
    .overrun  (overrun)
  );

  slot_seq_flags #(
    .NUM_GROUPS  (NUM_GROUPS),
    .CH_PER_GROUP(CH_PER_GROUP)
  ) u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .cmpFire(cmpFire),
    .chanIdx(chanIdx),
    .ovfBit (ovfBit)
  );

  assign sampleBank = bankSel;
  assign readBank   = ~bankSel;

endmodule

// File: rtl/slot_readout_seq_chk.sv
module slot_readout_seq_chk #(
  parameter int NUM_GROUPS   = 6,
  parameter int CH_PER_GROUP = 16,
  localparam int IDX_W       = $clog2(CH_PER_GROUP)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  slotCtrl,
  input logic                  sampleBank,
  input logic                  sampleEn,
  input logic                  scanValid,
  input logic [IDX_W-1:0]      chanIdx,
  input logic [NUM_GROUPS-1:0] ovfBit,
  input logic                  feReset,
  input logic                  overrun
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CH_PER_GROUP - 1);

  // R2: the bank flips only two edges after a slot-control rise
  assert_bank_flip_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sampleBank) |-> ($past(slotCtrl, 2) && !$past(slotCtrl, 3)));

  // R3: sampling never overlaps readout or the reset pulse
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleEn && (scanValid || feReset)));

  // R4: a scan starts at channel 0
  assert_scan_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scanValid) |-> (chanIdx == '0));

  // R4: without a new slot, the index steps by one
  assert_scan_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (scanValid && chanIdx != LAST_IDX && !($past(slotCtrl) && !$past(slotCtrl, 2)))
      |=> (scanValid && chanIdx == $past(chanIdx) + 1'b1));

  // R5: flags are silent outside the scan
  assert_ovf_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !scanValid |-> (ovfBit == '0));

  // R7: the last channel is followed by the reset pulse
  assert_reset_after_scan_R7: assert property (@(posedge clk) disable iff (!rstN)
    (scanValid && chanIdx == LAST_IDX && !($past(slotCtrl) && !$past(slotCtrl, 2)))
      |=> (feReset && !scanValid));

  // R9: overrun is sticky
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R9: raising overrun ends readout
  assert_overrun_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> (!scanValid && !feReset));

endmodule

bind slot_readout_seq slot_readout_seq_chk #(
  .NUM_GROUPS  (NUM_GROUPS),
  .CH_PER_GROUP(CH_PER_GROUP)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .slotCtrl  (slotCtrl),
  .sampleBank(sampleBank),
  .sampleEn  (sampleEn),
  .scanValid (scanValid),
  .chanIdx   (chanIdx),
  .ovfBit    (ovfBit),
  .feReset   (feReset),
  .overrun   (overrun)
);

// File: tb/slot_readout_seq_tb.sv
`timescale 1ns/1ps
module slot_readout_seq_tb;

  localparam int NG   = 6;
  localparam int CPG  = 16;
  localparam int NCH  = NG * CPG;
  localparam int NONE = 127;

  // vector: {fire channel (127 = none), fire before sampling, rstWidth, active cycles}
  localparam logic [19:0] VEC [8] = '{
    {7'd5,   1'b0, 4'd3, 8'd6},
    {7'd90,  1'b0, 4'd1, 8'd4},
    {7'd127, 1'b0, 4'd0, 8'd5},
    {7'd0,   1'b1, 4'd2, 8'd5},
    {7'd95,  1'b0, 4'd4, 8'd7},
    {7'd31,  1'b0, 4'd2, 8'd4},
    {7'd127, 1'b0, 4'd5, 8'd6},
    {7'd47,  1'b0, 4'd1, 8'd5}
  };

  logic           clk = 1'b0;
  logic           rstN;
  logic           slotCtrl;
  logic [NCH-1:0] cmpFire;
  logic [3:0]     rstWidth;
  logic           sampleBank, readBank, sampleEn, scanValid, feReset, overrun;
  logic [3:0]     chanIdx;
  logic [NG-1:0]  ovfBit;

  int  checks = 0;
  int  errors = 0;
  int  prevCh = NONE;
  logic expBank = 1'b0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  slot_readout_seq u_dut (
    .clk(clk), .rstN(rstN), .slotCtrl(slotCtrl), .cmpFire(cmpFire),
    .rstWidth(rstWidth), .sampleBank(sampleBank), .readBank(readBank),
    .sampleEn(sampleEn), .scanValid(scanValid), .chanIdx(chanIdx),
    .ovfBit(ovfBit), .feReset(feReset), .overrun(overrun)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] expOvf(input int ch, input int idx);
    logic [NG-1:0] v = '0;
    if (ch != NONE && (ch % CPG) == idx) v[ch / CPG] = 1'b1;
    return v;
  endfunction

  // Called right after slotCtrl has been driven low at a falling edge
  task automatic scanCheck(input int expCh, input int rw);
    int w = (rw == 0) ? 1 : rw;
    @(negedge clk);
    chk(!sampleEn, "R3 sampleEn low after fall", int'(sampleEn), 0);
    chk(!scanValid, "R4 scan not yet started", int'(scanValid), 0);
    for (int i = 0; i < CPG; i++) begin
      @(negedge clk);
      chk(scanValid && chanIdx == i, "R4 scan index", int'(chanIdx), i);
      chk(ovfBit == expOvf(expCh, i), "R5 ovfBit during scan", int'(ovfBit),
          int'(expOvf(expCh, i)));
    end
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      chk(feReset && !scanValid, "R7 feReset pulse", int'(feReset), 1);
    end
    @(negedge clk);
    chk(!feReset, "R7 feReset ends", int'(feReset), 0);
    chk(ovfBit == '0, "R5 ovfBit quiet after scan", int'(ovfBit), 0);
  endtask

  // Starts a slot at a falling edge, samples, ends the active phase
  task automatic activePhase(input int ch, input logic early, input int act);
    slotCtrl = 1'b1;
    if (early && ch != NONE) cmpFire[ch] = 1'b1;
    @(negedge clk);
    cmpFire = '0;
    chk(!sampleEn, "R3 sampleEn not yet high", int'(sampleEn), 0);
    @(negedge clk);
    expBank = ~expBank;
    chk(sampleBank == expBank && readBank == ~expBank, "R2 bank flip",
        int'(sampleBank), int'(expBank));
    chk(sampleEn, "R3 sampleEn high", int'(sampleEn), 1);
    if (!early && ch != NONE) cmpFire[ch] = 1'b1;
    @(negedge clk);
    cmpFire = '0;
    repeat (act - 3) @(negedge clk);
    slotCtrl = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; slotCtrl = 1'b0; cmpFire = '0; rstWidth = '0;
    repeat (3) @(negedge clk);
    chk(sampleBank == 0 && readBank == 1, "R1 banks in reset", int'(sampleBank), 0);
    chk(!sampleEn && !scanValid && !feReset && !overrun && ovfBit == '0,
        "R1 strobes in reset", int'({sampleEn, scanValid, feReset, overrun}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(sampleBank == 0 && !scanValid && !feReset && !overrun && ovfBit == '0,
        "R1 state after release", int'({sampleBank, scanValid, feReset, overrun}), 0);

    // Slot walk: each scan shows the previous slot's firing (R5, R6, R8)
    for (int v = 0; v < 8; v++) begin
      int   ch    = int'(VEC[v][19:13]);
      logic early = VEC[v][12];
      rstWidth = VEC[v][11:8];
      activePhase(ch, early, int'(VEC[v][7:0]));
      scanCheck(prevCh, int'(VEC[v][11:8]));
      prevCh = (early || ch == NONE) ? NONE : ch; // R6: early firing ignored
      repeat (3) @(negedge clk);
    end
    chk(!overrun, "R10 no overrun with full readout", int'(overrun), 0);

    // Overrun: channel 10 fired in slot A, slot B scan cut at index 5 (R9)
    rstWidth = 4'd2;
    activePhase(10, 1'b0, 5);
    scanCheck(prevCh, 2);
    repeat (2) @(negedge clk);
    activePhase(NONE, 1'b0, 5);
    repeat (7) @(negedge clk);       // scan index 5 now showing
    chk(scanValid && chanIdx == 5, "R9 scan running before abort", int'(chanIdx), 5);
    slotCtrl = 1'b1;
    @(negedge clk);
    chk(scanValid && !overrun, "R9 abort not yet taken", int'(overrun), 0);
    @(negedge clk);
    expBank = ~expBank;
    chk(overrun, "R9 overrun raised", int'(overrun), 1);
    chk(!scanValid && !feReset, "R9 readout stopped", int'({scanValid, feReset}), 0);
    chk(sampleBank == expBank, "R2 bank flip at overrun", int'(sampleBank), int'(expBank));
    repeat (3) @(negedge clk);
    slotCtrl = 1'b0;
    scanCheck(NONE, 2);              // slot B wrote nothing
    repeat (2) @(negedge clk);
    activePhase(NONE, 1'b0, 4);
    scanCheck(NONE, 2);              // R9: bank of slot A cleared by abort
    chk(overrun, "R9 overrun stays set", int'(overrun), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule